// File: doc/BRIEF.md
# Free-Running Match Timer with Four Compare Channels

This block keeps a 32-bit counter that steps up by one on every cycle where a tick-enable input is high. It never stops, never reloads on its own, and rolls over from all-ones to zero. The block has four compare channels, and each one holds its own 32-bit target value. When the counter steps onto a channel's target, that channel raises a sticky event flag. The counter carries on counting without any change.

Software drives the block over a small synchronous register bus. Periodic events are made by adding a period to the previous target, with modulo-2^32 arithmetic, and writing the sum back. An event flag is cleared by writing a one to its bit. A per-channel mask passes the flags to one interrupt line per channel, and a further line is the OR of all four.

Top module: `mct_timer`

## Requirements
- R1: After a synchronous reset the counter, all four targets, the event flags and the mask all read zero, and every interrupt output is low.
- R2: The counter increases by exactly one on each clock edge where `tick_en` is high. On any other edge it keeps its value.
- R3: Stepping from 0xFFFFFFFF gives 0x00000000.
- R4: A bus write to byte offset 0x10 loads the counter, and on that edge the write takes priority over a tick. A read of 0x10 returns the live count.
- R5: The target of channel i is written and read at byte offset 4*i, with i from 0 to 3.
- R6: The flag of channel i, at bit i of offset 0x14, becomes set on the edge where a tick moves the counter onto target i. A bus write that loads the counter with the target value does not set the flag, and the counter keeps counting after a match.
- R7: A write to 0x14 clears each flag whose data bit is one. Flags whose data bit is zero are left unchanged.
- R8: If a tick match on a channel and a clear of that channel's flag fall on the same edge, the flag ends up set.
- R9: The mask sits at offset 0x1C, with bit i belonging to channel i. `irq_ch[i]` is flag i AND mask bit i, and `irq_any` is the OR of the four `irq_ch` bits.
- R10: A target that the counter has already passed raises no event until the counter wraps around and steps onto that target.
- R11: Reads of unmapped offsets (0x18, anything above 0x1C) and of addresses whose bits [1:0] are not zero return zero. Writes to such addresses change nothing.
- R12: Read data appears on `bus_rdata` on the edge that accepts the read, and it holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Count-step qualifier |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_ch | output | 4 | Per-channel masked interrupt |
| irq_any | output | 1 | OR of all channel interrupts |

## Verification
Every bus write takes effect on the edge that accepts it. A read returns data on that same edge, so the bench drives each access for one cycle from a falling edge and looks at the result on the next falling edge. A flag set by a tick is visible on the edge after the tick-high cycle. The interrupt outputs are combinational from the flag and mask registers, so they follow the flag in the same cycle without any further delay. A behavioural model in the bench is advanced on each rising edge and compared with `bus_rdata`, `irq_ch` and `irq_any` on every falling edge. Directed reads pin down the exact counts around matches, wrap and priority cases.

// File: rtl/mct_pkg.sv
`timescale 1ns/1ps
package mct_pkg;

    localparam int unsigned BUS_AW  = 8;
    localparam int unsigned WORD_W  = BUS_AW - 2;
    localparam int unsigned MAX_CH  = 4;

    // word offsets (byte offset / 4)
    localparam logic [WORD_W-1:0] W_COUNT  = WORD_W'(4);
    localparam logic [WORD_W-1:0] W_STATUS = WORD_W'(5);
    localparam logic [WORD_W-1:0] W_ENABLE = WORD_W'(7);

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_MATCH,
        SEL_COUNT,
        SEL_STATUS,
        SEL_ENABLE
    } reg_sel_e;

    typedef struct packed {
        logic              wr;
        logic              rd;
        reg_sel_e          target;
        logic [WORD_W-1:0] word;
    } bus_req_t;

    function automatic reg_sel_e mct_decode(input logic [WORD_W-1:0] w,
                                            input logic [1:0]        lsb);
        reg_sel_e s;
        s = SEL_NONE;
        if (lsb == 2'b00) begin
            if (w < WORD_W'(MAX_CH))  s = SEL_MATCH;
            else if (w == W_COUNT)    s = SEL_COUNT;
            else if (w == W_STATUS)   s = SEL_STATUS;
            else if (w == W_ENABLE)   s = SEL_ENABLE;
        end
        return s;
    endfunction

endpackage

// File: rtl/mct_counter.sv
`timescale 1ns/1ps
module mct_counter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count_q,
    output logic [CNT_W-1:0] count_next,
    output logic             advance
);

    always_comb begin
        advance    = tick_en && !load_en;
        count_next = count_q + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)          count_q <= '0;
        else if (load_en) count_q <= load_val;
        else if (tick_en) count_q <= count_next;
    end

    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        tick_en && !load_en |=> count_q == $past(count_q) + CNT_W'(1));
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !tick_en && !load_en |=> $stable(count_q));
    p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        tick_en && !load_en && (count_q == '1) |=> count_q == '0);
    p_load_r4: assert property (@(posedge clk) disable iff (rst)
        load_en |=> count_q == $past(load_val));

endmodule

// File: rtl/mct_channel.sv
`timescale 1ns/1ps
module mct_channel #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             match_we,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             clr,
    input  logic             advance,
    input  logic [CNT_W-1:0] count_next,
    output logic [CNT_W-1:0] match_q,
    output logic             status_q
);

    logic hit;

    // compare against the post-increment value: one hit per pass
    always_comb hit = advance && (count_next == match_q);

    always_ff @(posedge clk) begin
        if (rst)           match_q <= '0;
        else if (match_we) match_q <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) status_q <= 1'b0;
        else     status_q <= (status_q && !clr) || hit;
    end

    p_target_r5: assert property (@(posedge clk) disable iff (rst)
        match_we |=> match_q == $past(wr_data));
    p_set_r6: assert property (@(posedge clk) disable iff (rst)
        hit |=> status_q);
    p_clear_r7: assert property (@(posedge clk) disable iff (rst)
        clr && !hit |=> !status_q);
    p_keep_r7: assert property (@(posedge clk) disable iff (rst)
        !clr && !hit |=> status_q == $past(status_q));
    p_setwins_r8: assert property (@(posedge clk) disable iff (rst)
        clr && hit |=> status_q);

endmodule

// File: rtl/mct_regbus.sv
`timescale 1ns/1ps
module mct_regbus
    import mct_pkg::*;
#(
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned NUM_CH = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          bus_sel,
    input  logic                          bus_wr,
    input  logic [BUS_AW-1:0]             bus_addr,
    input  logic [CNT_W-1:0]              bus_wdata,
    input  logic [CNT_W-1:0]              count_q,
    input  logic [NUM_CH-1:0][CNT_W-1:0]  match_q,
    input  logic [NUM_CH-1:0]             status_q,
    output logic                          cnt_we,
    output logic [NUM_CH-1:0]             match_we,
    output logic [NUM_CH-1:0]             st_clr,
    output logic [NUM_CH-1:0]             enable_q,
    output logic [CNT_W-1:0]              bus_rdata
);

    bus_req_t         req;
    logic [CNT_W-1:0] rd_mux;

    always_comb begin
        req.wr     = bus_sel && bus_wr;
        req.rd     = bus_sel && !bus_wr;
        req.word   = bus_addr[BUS_AW-1:2];
        req.target = mct_decode(bus_addr[BUS_AW-1:2], bus_addr[1:0]);
        cnt_we     = req.wr && (req.target == SEL_COUNT);
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch_dec
        always_comb begin
            match_we[ch] = req.wr && (req.target == SEL_MATCH)
                           && (req.word == WORD_W'(ch));
            st_clr[ch]   = req.wr && (req.target == SEL_STATUS) && bus_wdata[ch];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            enable_q <= '0;
        else if (req.wr && req.target == SEL_ENABLE)
            enable_q <= bus_wdata[NUM_CH-1:0];
    end

    always_comb begin
        rd_mux = '0;
        unique case (req.target)
            SEL_MATCH: begin
                for (int i = 0; i < NUM_CH; i++)
                    if (req.word == WORD_W'(i)) rd_mux = match_q[i];
            end
            SEL_COUNT:  rd_mux = count_q;
            SEL_STATUS: rd_mux[NUM_CH-1:0] = status_q;
            SEL_ENABLE: rd_mux[NUM_CH-1:0] = enable_q;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (req.rd) bus_rdata <= rd_mux;
    end

    p_unmapped_r11: assert property (@(posedge clk) disable iff (rst)
        req.rd && req.target == SEL_NONE |=> bus_rdata == '0);
    p_rdhold_r12: assert property (@(posedge clk) disable iff (rst)
        !req.rd |=> $stable(bus_rdata));
    p_mask_r9: assert property (@(posedge clk) disable iff (rst)
        req.wr && req.target == SEL_ENABLE |=> enable_q == $past(bus_wdata[NUM_CH-1:0]));

endmodule

// File: rtl/mct_timer.sv
`timescale 1ns/1ps
module mct_timer
    import mct_pkg::*;
#(
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic [NUM_CH-1:0] irq_ch,
    output logic              irq_any
);

    logic [CNT_W-1:0]             count_q;
    logic [CNT_W-1:0]             count_next;
    logic                         advance;
    logic                         cnt_we;
    logic [NUM_CH-1:0]            match_we;
    logic [NUM_CH-1:0]            st_clr;
    logic [NUM_CH-1:0]            enable_q;
    logic [NUM_CH-1:0]            status_q;
    logic [NUM_CH-1:0][CNT_W-1:0] match_q;

    mct_counter #(.CNT_W(CNT_W)) u_counter (
        .clk        (clk),
        .rst        (rst),
        .tick_en    (tick_en),
        .load_en    (cnt_we),
        .load_val   (bus_wdata),
        .count_q    (count_q),
        .count_next (count_next),
        .advance    (advance)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        mct_channel #(.CNT_W(CNT_W)) u_chan (
            .clk        (clk),
            .rst        (rst),
            .match_we   (match_we[ch]),
            .wr_data    (bus_wdata),
            .clr        (st_clr[ch]),
            .advance    (advance),
            .count_next (count_next),
            .match_q    (match_q[ch]),
            .status_q   (status_q[ch])
        );
    end

    mct_regbus #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_regbus (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .count_q   (count_q),
        .match_q   (match_q),
        .status_q  (status_q),
        .cnt_we    (cnt_we),
        .match_we  (match_we),
        .st_clr    (st_clr),
        .enable_q  (enable_q),
        .bus_rdata (bus_rdata)
    );

    always_comb begin
        irq_ch  = status_q & enable_q;
        irq_any = |irq_ch;
    end

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (count_q == '0) && (status_q == '0) && (enable_q == '0));

endmodule

// File: tb/mct_timer_bench.sv
`timescale 1ns/1ps
module mct_timer_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq_ch;
    logic        irq_any;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    mct_timer u_mct_timer (
        .clk(clk), .rst(rst), .tick_en(tick_en), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_ch(irq_ch), .irq_any(irq_any)
    );

    // ---------------- behavioural reference ----------------
    logic [31:0] m_cnt;
    logic [31:0] m_tgt [4];
    logic [3:0]  m_flag;
    logic [3:0]  m_mask;
    logic [31:0] m_rd;
    bit          m_live = 0;

    function automatic logic [31:0] m_read(input logic [7:0] a);
        if (a[1:0] != 2'b00) return 32'h0;
        if (a < 8'h10)       return m_tgt[a[3:2]];
        if (a == 8'h10)      return m_cnt;
        if (a == 8'h14)      return {28'h0, m_flag};
        if (a == 8'h1C)      return {28'h0, m_mask};
        return 32'h0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_flag = 0; m_mask = 0; m_rd = 0;
            foreach (m_tgt[k]) m_tgt[k] = 0;
            m_live = 0;
        end else begin
            logic        wr_cnt;
            logic [31:0] stepped;
            logic [3:0]  ev;
            logic [3:0]  clr;
            wr_cnt  = bus_sel && bus_wr && bus_addr == 8'h10;
            stepped = m_cnt + 1;
            for (int k = 0; k < 4; k++)
                ev[k] = tick_en && !wr_cnt && (stepped == m_tgt[k]);
            clr = (bus_sel && bus_wr && bus_addr == 8'h14) ? bus_wdata[3:0] : 4'h0;
            if (bus_sel && !bus_wr) m_rd = m_read(bus_addr);
            if (bus_sel && bus_wr && bus_addr[1:0] == 2'b00 && bus_addr < 8'h10)
                m_tgt[bus_addr[3:2]] = bus_wdata;
            if (bus_sel && bus_wr && bus_addr == 8'h1C) m_mask = bus_wdata[3:0];
            m_flag = (m_flag & ~clr) | ev;
            if (wr_cnt)       m_cnt = bus_wdata;
            else if (tick_en) m_cnt = stepped;
            m_live = 1;
        end
    end

    always @(negedge clk) begin
        if (m_live) begin
            checks++;
            if (bus_rdata !== m_rd) begin
                errors++;
                $display("FAIL R12 model rdata: got %h expected %h", bus_rdata, m_rd);
            end
            checks++;
            if (irq_ch !== (m_flag & m_mask) || irq_any !== |(m_flag & m_mask)) begin
                errors++;
                $display("FAIL R9 model irq: got %b/%b expected %b/%b",
                         irq_ch, irq_any, m_flag & m_mask, |(m_flag & m_mask));
            end
        end
    end

    // ---------------- directed helpers ----------------
    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        @(negedge clk);
        bus_sel = 0;
        chk(bus_rdata, exp, tag);
    endtask

    task automatic ticks(input int n);
        tick_en = 1;
        repeat (n) @(negedge clk);
        tick_en = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk({27'h0, irq_any, irq_ch}, 32'h0, "R1 irq");
        rd_chk(8'h10, 0, "R1 counter");
        for (int i = 0; i < 4; i++) rd_chk(8'(4*i), 0, "R1 target");
        rd_chk(8'h14, 0, "R1 flags");
        rd_chk(8'h1C, 0, "R1 mask");

        // R5 target registers
        for (int i = 0; i < 4; i++) wr(8'(4*i), 32'h20 * (i + 1));
        for (int i = 0; i < 4; i++) rd_chk(8'(4*i), 32'h20 * (i + 1), "R5 target");

        // R2 counting only with tick_en
        ticks(10);
        rd_chk(8'h10, 10, "R2 ten ticks");
        repeat (4) @(negedge clk);
        rd_chk(8'h10, 10, "R2 hold");

        // R4 load, and load beats tick
        wr(8'h10, 32'h1234);
        rd_chk(8'h10, 32'h1234, "R4 load");
        tick_en = 1;
        wr(8'h10, 32'h500);
        tick_en = 0;
        rd_chk(8'h10, 32'h500, "R4 load over tick");

        // R6 load onto target gives no event, tick onto target does
        wr(8'h10, 32'h20);
        rd_chk(8'h14, 0, "R6 load no event");
        wr(8'h10, 32'h1E);
        ticks(2);
        rd_chk(8'h14, 1, "R6 event ch0");
        ticks(3);
        rd_chk(8'h10, 32'h23, "R6 keeps counting");

        // R9 mask
        chk({31'h0, irq_any}, 0, "R9 masked off");
        wr(8'h1C, 3);
        chk({28'h0, irq_ch}, 4'b0001, "R9 irq_ch");
        chk({31'h0, irq_any}, 1, "R9 irq_any");
        rd_chk(8'h1C, 3, "R9 mask read");

        // R7 write-one-to-clear
        wr(8'h10, 32'h3F);
        ticks(1);
        chk({28'h0, irq_ch}, 4'b0011, "R9 two channels");
        wr(8'h14, 2);
        rd_chk(8'h14, 1, "R7 clear bit1");
        wr(8'h14, 0);
        rd_chk(8'h14, 1, "R7 zero write");
        wr(8'h14, 32'hF);
        rd_chk(8'h14, 0, "R7 clear all");
        chk({31'h0, irq_any}, 0, "R7 irq dropped");

        // R8 event and clear on the same edge
        wr(8'h10, 32'h5F);
        tick_en = 1;
        wr(8'h14, 4);
        tick_en = 0;
        rd_chk(8'h14, 4, "R8 set wins");

        // R10 passed target waits for wrap
        wr(8'h14, 32'hF);
        wr(8'h0C, 32'h50);
        ticks(32'h40);
        rd_chk(8'h14, 0, "R10 no event before wrap");
        wr(8'h10, 32'hFFFF_FFF0);
        ticks(32'h60);
        rd_chk(8'h10, 32'h50, "R10 count after wrap");
        rd_chk(8'h14, 4'b1011, "R10 event after wrap");

        // R3 wrap
        wr(8'h10, 32'hFFFF_FFFE);
        ticks(3);
        rd_chk(8'h10, 1, "R3 wrap");

        // R11 unmapped and misaligned
        rd_chk(8'h18, 0, "R11 read 0x18");
        rd_chk(8'h11, 0, "R11 misaligned read");
        rd_chk(8'h20, 0, "R11 read 0x20");
        wr(8'h18, 32'hFFFF_FFFF);
        wr(8'h12, 32'h0);
        wr(8'h1D, 32'h0);
        rd_chk(8'h10, 1, "R11 counter untouched");
        rd_chk(8'h1C, 3, "R11 mask untouched");

        // R12 read data holds between reads
        rd_chk(8'h10, 1, "R12 read");
        ticks(5);
        chk(bus_rdata, 1, "R12 hold");
        rd_chk(8'h10, 6, "R12 new read");

        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule